// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block holds a 24-hour clock and a calendar date as packed BCD fields and moves them forward by one second on each single-cycle `tick` pulse, which a prescaler outside the block supplies at 1 Hz. The host never sees the live counters directly. It reads a pair of shadow words, one for time and one for date, that are refreshed together one cycle after a counted tick, so both words always come from the same second.

To set the clock, the host raises `init_req`. The control state machine moves from RUN to INIT, and `init_active` reports that INIT has been reached. In INIT the counters stop and the host may load the time word, the date word, or both. When `init_req` falls, the machine enters RESYNC. The counters run again from the loaded values, but the shadow words stay frozen until `SYNC_TICKS` ticks have passed. The machine then refreshes the shadows, raises `sync_ready` and returns to RUN. The host can clear `sync_ready` with `sync_clr` and watch for it to come back at the next refresh.

The state machine has three states:
- RUN: counting, with a shadow refresh after every tick. It goes to INIT when `init_req` is high.
- INIT: frozen and loadable. It goes to RESYNC when `init_req` is low.
- RESYNC: counting without refresh. It returns to INIT on `init_req`, and goes to RUN on the tick that completes the `SYNC_TICKS` window.

Top module: `bcd_calendar`

## Requirements
- R1: Time word layout is seconds at [6:0] and minutes at [14:8]. Each counts BCD 00 to 59, wraps to 00 and carries into the next field.
- R2: Hours sit at [21:16] and count BCD 00 to 23 (24-hour only). The wrap to 00 carries one day into the date word.
- R3: Date word layout is day at [5:0], month at [12:8], weekday (binary) at [15:13] and year at [23:16]. The day restarts at 01 after 30 in months 04, 06, 09 and 11, after 31 in the other months, and after 28 in month 02 of a non-leap year.
- R4: When the BCD year is a multiple of four, month 02 runs to day 29 before restarting at 01.
- R5: Month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00. The weekday steps by one on each day carry and wraps from 7 to 1.
- R6: `init_active` is high exactly while the machine is in INIT. Loads take effect only in INIT, and load strobes at other times are ignored. Ticks in INIT do not advance the counters.
- R7: After INIT is left, counting resumes from the loaded values. The shadows and `sync_ready` are refreshed only on the `SYNC_TICKS`-th tick after exit.
- R8: `sync_ready` goes low on `sync_clr` and while in INIT. It goes high on each shadow refresh, and a refresh takes priority over `sync_clr`.
- R9: After reset, every output reads zero. In RUN, the shadows take the live pair in the cycle after a tick and hold it otherwise.
- R10: Loading all-zero time and date words is legal, and counting proceeds from 00:00:00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, one per second |
| init_req | input | 1 | Host request to stop the counters and allow loads |
| wr_time | input | 1 | Load strobe for the time word |
| wr_date | input | 1 | Load strobe for the date word |
| wr_data | input | 24 | Packed BCD value for the load |
| sync_clr | input | 1 | Host clear of the ready flag |
| init_active | output | 1 | Machine is in INIT |
| sync_ready | output | 1 | Shadows refreshed since the last clear |
| time_rd | output | 24 | Shadow time word |
| date_rd | output | 24 | Shadow date word |

## Verification
The bench builds the block with `SYNC_TICKS` set to 3 rather than the default of 2. This makes the RESYNC window long enough that ticks inside it still advance the counters while `sync_ready` stays low. Loads placed just before a carry reach each rollover within a few ticks: end of minute, end of hour, February in both leap and non-leap years, a 30-day month and the end of the century. A free run that ticks on every cycle, with periodic `sync_clr` pulses, carries the time across midnight into a leap day.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int WORD_W = 24;

    typedef enum logic [1:0] {
        CAL_RUN    = 2'd0,
        CAL_INIT   = 2'd1,
        CAL_RESYNC = 2'd2
    } cal_state_e;

    // Two-digit BCD increment without any wrap check.
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    // BCD year divisible by four: even tens take units 0/4/8, odd tens take 2/6.
    function automatic logic is_leap(input logic [7:0] yr);
        logic r;
        if (yr[4]) r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else       r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
        return r;
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon, input logic leap);
        logic [7:0] r;
        case (mon)
            8'h02:                      r = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
            default:                    r = 8'h31;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
    import cal_pkg::*;
#(
    parameter int SYNC_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic init_req,
    input  logic sync_clr,
    output logic run_en,
    output logic load_en,
    output logic copy_pend,
    output logic sync_ready,
    output logic init_active
);

    localparam int CNT_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_TICKS - 1);

    cal_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             resync_done;

    assign resync_done = (state_q == CAL_RESYNC) && tick && (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            CAL_RUN: begin
                if (init_req) state_d = CAL_INIT;
            end
            CAL_INIT: begin
                if (!init_req) begin
                    state_d = CAL_RESYNC;
                    cnt_d   = '0;
                end
            end
            CAL_RESYNC: begin
                if (init_req)         state_d = CAL_INIT;
                else if (resync_done) state_d = CAL_RUN;
                else if (tick)        cnt_d   = cnt_q + 1'b1;
            end
            default: state_d = CAL_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAL_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            copy_pend  <= 1'b0;
            sync_ready <= 1'b0;
        end else begin
            copy_pend <= tick && ((state_q == CAL_RUN) || resync_done);
            if (state_q == CAL_INIT) sync_ready <= 1'b0;
            else if (copy_pend)      sync_ready <= 1'b1;
            else if (sync_clr)       sync_ready <= 1'b0;
        end
    end

    assign run_en      = (state_q != CAL_INIT);
    assign load_en     = (state_q == CAL_INIT);
    assign init_active = load_en;

    a_r8_ready_on_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_pend && state_q != CAL_INIT) |=> sync_ready);

    a_r8_init_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_INIT) |=> !sync_ready);

    a_r7_no_refresh_in_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAL_RESYNC && !resync_done) |=> !copy_pend);

    a_r6_init_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_req && state_q != CAL_INIT) |=> (state_q != CAL_INIT));

endmodule

// File: rtl/cal_time_cnt.sv
module cal_time_cnt
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] time_word,
    output logic              day_carry
);

    localparam int N_MS = 2;

    logic [N_MS:0]        adv;
    logic [N_MS-1:0][7:0] ms_val;
    logic [7:0]           hr_q;

    assign adv[0] = step;

    // Seconds (index 0) and minutes (index 1) share one 00..59 digit pair.
    for (genvar g = 0; g < N_MS; g++) begin : g_ms
        logic [7:0] val_q;
        logic       at_max;

        assign at_max = (val_q == 8'h59);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      val_q <= 8'h00;
            else if (load)   val_q <= load_word[g*8 +: 8] & 8'h7F;
            else if (adv[g]) val_q <= at_max ? 8'h00 : bcd_next(val_q);
        end

        assign adv[g+1]  = adv[g] & at_max;
        assign ms_val[g] = val_q;

        a_r1_field_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (adv[g] && !load && at_max) |=> (val_q == 8'h00));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hr_q <= 8'h00;
        else if (load)       hr_q <= load_word[23:16] & 8'h3F;
        else if (adv[N_MS])  hr_q <= (hr_q == 8'h23) ? 8'h00 : bcd_next(hr_q);
    end

    assign day_carry = adv[N_MS] && (hr_q == 8'h23);
    assign time_word = {hr_q, ms_val[1], ms_val[0]};

    a_r2_hour_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (day_carry && !load) |=> (hr_q == 8'h00));

    a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(time_word));

endmodule

// File: rtl/cal_date_cnt.sv
module cal_date_cnt
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] date_word
);

    logic [7:0] day_q;
    logic [4:0] mon_q;
    logic [2:0] wd_q;
    logic [7:0] yr_q;
    logic [7:0] day_last;
    logic       month_end;
    logic       year_end;

    assign day_last  = last_day({3'b000, mon_q}, is_leap(yr_q));
    assign month_end = (day_q == day_last);
    assign year_end  = month_end && (mon_q == 5'h12);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    day_q <= 8'h00;
        else if (load) day_q <= load_word[7:0] & 8'h3F;
        else if (step) day_q <= month_end ? 8'h01 : bcd_next(day_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 mon_q <= 5'h00;
        else if (load)              mon_q <= load_word[12:8];
        else if (step && month_end) mon_q <= year_end ? 5'h01 : 5'(bcd_next({3'b000, mon_q}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                yr_q <= 8'h00;
        else if (load)             yr_q <= load_word[23:16];
        else if (step && year_end) yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_next(yr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    wd_q <= 3'd0;
        else if (load) wd_q <= load_word[15:13];
        else if (step) wd_q <= (wd_q == 3'd7) ? 3'd1 : wd_q + 3'd1;
    end

    assign date_word = {yr_q, wd_q, mon_q, day_q};

    a_r3_day_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && month_end) |=> (day_q == 8'h01));

    a_r4_leap_day: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mon_q == 5'h02 && day_q == 8'h28 && yr_q == 8'h24) |=> (day_q == 8'h29));

    a_r5_century_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && year_end && yr_q == 8'h99) |=> (yr_q == 8'h00 && mon_q == 5'h01));

    a_r5_weekday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && wd_q == 3'd7) |=> (wd_q == 3'd1));

endmodule

// File: rtl/cal_shadow.sv
module cal_shadow
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              copy,
    input  logic [WORD_W-1:0] live_time,
    input  logic [WORD_W-1:0] live_date,
    output logic [WORD_W-1:0] time_rd,
    output logic [WORD_W-1:0] date_rd
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_rd <= '0;
            date_rd <= '0;
        end else if (copy) begin
            time_rd <= live_time;
            date_rd <= live_date;
        end
    end

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !copy |=> ($stable(time_rd) && $stable(date_rd)));

    a_r9_pair_capture: assert property (@(posedge clk) disable iff (!rst_n)
        copy |=> (time_rd == $past(live_time) && date_rd == $past(live_date)));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int SYNC_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              init_req,
    input  logic              wr_time,
    input  logic              wr_date,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sync_clr,
    output logic              init_active,
    output logic              sync_ready,
    output logic [WORD_W-1:0] time_rd,
    output logic [WORD_W-1:0] date_rd
);

    logic              run_en;
    logic              load_en;
    logic              copy_pend;
    logic              day_carry;
    logic [WORD_W-1:0] live_time;
    logic [WORD_W-1:0] live_date;

    cal_ctrl #(.SYNC_TICKS(SYNC_TICKS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .init_req    (init_req),
        .sync_clr    (sync_clr),
        .run_en      (run_en),
        .load_en     (load_en),
        .copy_pend   (copy_pend),
        .sync_ready  (sync_ready),
        .init_active (init_active)
    );

    cal_time_cnt u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (tick & run_en),
        .load      (load_en & wr_time),
        .load_word (wr_data),
        .time_word (live_time),
        .day_carry (day_carry)
    );

    cal_date_cnt u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (day_carry),
        .load      (load_en & wr_date),
        .load_word (wr_data),
        .date_word (live_date)
    );

    cal_shadow u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .copy      (copy_pend),
        .live_time (live_time),
        .live_date (live_date),
        .time_rd   (time_rd),
        .date_rd   (date_rd)
    );

endmodule

// File: tb/test_bcd_calendar.sv
`timescale 1ns/1ps
module test_bcd_calendar;

    localparam int SYNC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        init_req = 1'b0;
    logic        wr_time = 1'b0;
    logic        wr_date = 1'b0;
    logic [23:0] wr_data = '0;
    logic        sync_clr = 1'b0;
    logic        init_active;
    logic        sync_ready;
    logic [23:0] time_rd;
    logic [23:0] date_rd;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bcd_calendar #(.SYNC_TICKS(SYNC)) i_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .tick(tick), .init_req(init_req),
        .wr_time(wr_time), .wr_date(wr_date), .wr_data(wr_data),
        .sync_clr(sync_clr), .init_active(init_active), .sync_ready(sync_ready),
        .time_rd(time_rd), .date_rd(date_rd)
    );

    // Behavioural reference model, binary integers.
    int m_sec, m_min, m_hr, m_day, m_mon, m_wd, m_yr;
    int m_st, m_cnt;
    bit m_pend, m_ready;
    logic [23:0] m_tr, m_dr;
    int o_st, o_cnt, last;
    bit o_pend;

    function automatic int b2bcd(input int v);
        return ((v / 10) * 16) + (v % 10);
    endfunction

    function automatic int bcd2b(input int v);
        return ((v / 16) * 10) + (v % 16);
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_mon = 0; m_wd = 0; m_yr = 0;
            m_st = 0; m_cnt = 0; m_pend = 0; m_ready = 0; m_tr = '0; m_dr = '0;
        end else begin
            o_st = m_st; o_cnt = m_cnt; o_pend = m_pend;
            if (o_pend) begin
                m_tr = 24'(b2bcd(m_hr) * 65536 + b2bcd(m_min) * 256 + b2bcd(m_sec));
                m_dr = 24'(b2bcd(m_yr) * 65536 + m_wd * 8192 + b2bcd(m_mon) * 256 + b2bcd(m_day));
            end
            if (o_st == 1) m_ready = 0;
            else if (o_pend) m_ready = 1;
            else if (sync_clr) m_ready = 0;
            m_pend = tick && (o_st == 0 || (o_st == 2 && o_cnt == SYNC - 1));
            if (o_st == 1) begin
                if (wr_time) begin
                    m_sec = bcd2b(int'(wr_data[6:0]));
                    m_min = bcd2b(int'(wr_data[14:8]));
                    m_hr  = bcd2b(int'(wr_data[21:16]));
                end
                if (wr_date) begin
                    m_day = bcd2b(int'(wr_data[5:0]));
                    m_mon = bcd2b(int'(wr_data[12:8]));
                    m_wd  = int'(wr_data[15:13]);
                    m_yr  = bcd2b(int'(wr_data[23:16]));
                end
            end else if (tick) begin
                if (m_sec == 59) begin
                    m_sec = 0;
                    if (m_min == 59) begin
                        m_min = 0;
                        if (m_hr == 23) begin
                            m_hr = 0;
                            last = days_in(m_mon, m_yr);
                            m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                            if (m_day == last) begin
                                m_day = 1;
                                if (m_mon == 12) begin
                                    m_mon = 1;
                                    m_yr = (m_yr == 99) ? 0 : m_yr + 1;
                                end else m_mon = m_mon + 1;
                            end else m_day = m_day + 1;
                        end else m_hr = m_hr + 1;
                    end else m_min = m_min + 1;
                end else m_sec = m_sec + 1;
            end
            case (o_st)
                0: if (init_req) m_st = 1;
                1: if (!init_req) begin m_st = 2; m_cnt = 0; end
                default: begin
                    if (init_req) m_st = 1;
                    else if (tick && o_cnt == SYNC - 1) m_st = 0;
                    else if (tick) m_cnt = m_cnt + 1;
                end
            endcase
        end
    end

    task automatic cmp(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R9 shadow time vs model", time_rd, m_tr);
            cmp("R3 shadow date vs model", date_rd, m_dr);
            cmp("R8 ready vs model", {23'd0, sync_ready}, {23'd0, m_ready});
            cmp("R6 init flag vs model", {23'd0, init_active}, {23'd0, m_st == 1});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL R7 watchdog expired actual=%0d expected=finish", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic do_tick;
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load_cal(input logic [23:0] t, input logic [23:0] d);
        @(negedge clk) init_req = 1'b1;
        @(negedge clk);
        cmp("R6 init_active in INIT", {23'd0, init_active}, 24'd1);
        wr_time = 1'b1; wr_data = t;
        @(negedge clk) wr_time = 1'b0; wr_date = 1'b1; wr_data = d;
        @(negedge clk) wr_date = 1'b0;
        cmp("R8 ready low in INIT", {23'd0, sync_ready}, 24'd0);
        do_tick;
        do_tick;
        init_req = 1'b0;
        @(negedge clk);
        cmp("R6 init_active after exit", {23'd0, init_active}, 24'd0);
        for (int k = 0; k < SYNC - 1; k++) do_tick;
        cmp("R7 ready waits for resync", {23'd0, sync_ready}, 24'd0);
        do_tick;
        cmp("R7 ready after resync", {23'd0, sync_ready}, 24'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R9 reset time", time_rd, 24'h000000);
        cmp("R9 reset date", date_rd, 24'h000000);
        cmp("R9 reset ready", {23'd0, sync_ready}, 24'd0);

        do_tick; do_tick; do_tick;
        cmp("R1 three seconds", time_rd, 24'h000003);
        cmp("R9 first refresh sets ready", {23'd0, sync_ready}, 24'd1);

        @(negedge clk) sync_clr = 1'b1;
        @(negedge clk) sync_clr = 1'b0;
        cmp("R8 sync_clr drops ready", {23'd0, sync_ready}, 24'd0);
        do_tick;
        cmp("R8 ready back after tick", {23'd0, sync_ready}, 24'd1);

        @(negedge clk) begin wr_time = 1'b1; wr_date = 1'b1; wr_data = 24'h123456; end
        @(negedge clk) begin wr_time = 1'b0; wr_date = 1'b0; end
        do_tick;
        cmp("R6 load outside INIT ignored time", time_rd, 24'h000005);
        cmp("R6 load outside INIT ignored date", date_rd, 24'h000000);

        load_cal(24'h235958, 24'h23E228);
        cmp("R2 midnight wrap time", time_rd, 24'h000001);
        cmp("R3 non-leap Feb to Mar", date_rd, 24'h232301);

        load_cal(24'h235959, 24'h246228);
        cmp("R4 leap Feb 29", date_rd, 24'h248229);
        cmp("R7 resumes from loaded time", time_rd, 24'h000002);

        load_cal(24'h235959, 24'h248229);
        cmp("R4 leap day to Mar", date_rd, 24'h24A301);

        load_cal(24'h235959, 24'h99F231);
        cmp("R5 century and weekday wrap", date_rd, 24'h002101);

        load_cal(24'h235959, 24'h214430);
        cmp("R3 thirty-day month", date_rd, 24'h216501);

        load_cal(24'h005959, 24'h214430);
        cmp("R1 minute carry into hour", time_rd, 24'h010002);
        cmp("R1 date untouched", date_rd, 24'h214430);

        load_cal(24'h095959, 24'h214430);
        cmp("R2 hour BCD 09 to 10", time_rd, 24'h100002);

        load_cal(24'h000000, 24'h000000);
        cmp("R10 zero load time", time_rd, 24'h000003);
        cmp("R10 zero load date", date_rd, 24'h000000);

        load_cal(24'h235900, 24'h24E228);
        @(negedge clk) tick = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk) sync_clr = (i % 13 == 5);
        end
        tick = 1'b0; sync_clr = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R4 free run reaches leap day", {16'd0, date_rd[7:0]}, 24'h000029);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule